// File: doc/BRIEF.md
# UART Link Sleep-Wake Controller

This block manages the power-state handshakes on a two-wire serial link between a radio co-processor and a host. It sits between the upper layers that produce outbound frames and the UART transmitter. It decides when a frame may leave, drives a dedicated active-high pin that wakes a sleeping host, and injects the short control frames the handshakes need: a sleep confirmation, a ping response and a single null byte.

Two sequences are covered. When the host asks the link to sleep, outbound frames are held in a local queue. The first held frame raises the wake pin. The next byte of any value from the host ends the wait: the pin drops, a ping response goes out, and then the queue drains in order. When the co-processor itself dozes, its transmitter is silent. After receive-line activity and receiver re-enable, a 0x00 byte from the host is answered with one 0x00 byte. Every other byte in that window is discarded.

The transmit side uses a valid/ready handshake. The output carries a kind code and a frame word; the serializer turns the word into bytes.

Top module: `lsw_ctrl`

## Requirements
- R1: After reset the host is treated as awake, `host_wake_o` is low, `overflow_o` is low and `tx_valid_o` is low.
- R2: While the host is awake and the co-processor is on, queued frames are offered head first with kind 0 (data), one leaving per cycle in which `tx_valid_o` and `tx_ready_i` are both high, in arrival order.
- R3: A `sleep_req_i` pulse arrives while `uart_busy_i` is low, the queue is empty and no transfer is offered. The host state becomes sleeping, and from the next cycle a kind 1 (confirm) transfer carrying `CFM_CMD` is offered.
- R4: A `sleep_req_i` pulse while `uart_busy_i` is high is ignored: no confirm is offered and later frames go out at once with `host_wake_o` staying low.
- R5: While the host is sleeping or being waited for, no kind 0 transfer is offered.
- R6: A frame accepted while the host is sleeping raises `host_wake_o` in the next cycle. The pin then stays high, without gaps, until a byte is received.
- R7: While waiting for the host, any received byte, whatever its value, drops `host_wake_o` in the next cycle. It also offers a kind 2 (ping response) transfer whose low byte is 0x10, ahead of any data frame.
- R8: Once the ping response is taken, every frame buffered during the host's sleep is offered in arrival order.
- R9: A frame pushed while the queue holds `DEPTH` frames is dropped and `overflow_o` goes high and stays high until reset. The queued frames are neither altered nor reordered.
- R10: After a `doze_i` pulse, `tx_valid_o` stays low, whatever is queued, until the null handshake of R11 completes.
- R11: After `rx_activity_i` ends the doze, bytes received while `rx_ready_i` is low, and nonzero bytes, are discarded. The first 0x00 byte received with `rx_ready_i` high leads, one cycle later, to a kind 3 (null) transfer of value 0. It is offered ahead of everything else, and normal traffic resumes after it.
- R12: Bytes received while the host is awake or asleep (not being waited for) change neither `host_wake_o` nor the offered transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | Decoded byte from the host is valid |
| rx_byte_i | input | 8 | Decoded received byte |
| sleep_req_i | input | 1 | Decoded enable-sleep request from the host (pulse) |
| uart_busy_i | input | 1 | Serial link busy |
| doze_i | input | 1 | Co-processor enters its own sleep (pulse) |
| rx_activity_i | input | 1 | Receive-line activity seen while dozing (pulse) |
| rx_ready_i | input | 1 | Receiver is fully re-enabled |
| frm_valid_i | input | 1 | Outbound frame push |
| frm_data_i | input | FRAME_W | Outbound frame word |
| tx_valid_o | output | 1 | Transfer offered to the transmitter |
| tx_kind_o | output | 2 | 0 data, 1 confirm, 2 ping response, 3 null |
| tx_data_o | output | FRAME_W | Transfer word |
| tx_ready_i | input | 1 | Transmitter takes the offered transfer |
| host_wake_o | output | 1 | Active-high host wake pin |
| overflow_o | output | 1 | Sticky queue overflow flag |

## Verification
Every result is due one cycle after its stimulus edge. The wake pin rises on the edge after the first held frame. The confirm, ping response and null byte appear on the edge after the sleep request, the ping byte or the zero byte. A queued data frame is visible on the edge after its push. The bench drives every input on the falling clock edge and samples on the following falling edge, so each check sees exactly one rising edge's worth of change. The bench holds `tx_ready_i` low while it inspects the offered transfer, then raises it for a single cycle to consume that transfer. Multi-cycle holds, such as the steady wake pin and the silent transmitter during a doze, are checked on each of several consecutive falling edges.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

    typedef enum logic [1:0] {
        HS_AWAKE = 2'd0,
        HS_SLEEP = 2'd1,
        HS_WAIT  = 2'd2
    } host_st_e;

    typedef enum logic [1:0] {
        LS_ON     = 2'd0,
        LS_DOZE   = 2'd1,
        LS_RESYNC = 2'd2
    } loc_st_e;

    typedef enum logic [1:0] {
        TK_DATA = 2'd0,
        TK_CFM  = 2'd1,
        TK_PING = 2'd2,
        TK_NULL = 2'd3
    } tx_kind_e;

    localparam logic [7:0] PING_CMD = 8'h10;

endpackage

// File: rtl/lsw_frame_fifo.sv
module lsw_frame_fifo #(
    parameter int FRAME_W = 16,
    parameter int DEPTH   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  logic [FRAME_W-1:0] data_i,
    input  logic               pop_i,
    output logic [FRAME_W-1:0] head_o,
    output logic               empty_o,
    output logic               push_ok_o,
    output logic               overflow_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
        logic          ovf;
    } fifo_t;

    fifo_t q, d;
    logic [FRAME_W-1:0] mem_q [DEPTH];
    logic full, do_pop;

    assign full      = (q.cnt == FULL);
    assign empty_o   = (q.cnt == '0);
    assign push_ok_o = push_i && !full;
    assign do_pop    = pop_i && !empty_o;
    assign head_o    = mem_q[q.rd];
    assign overflow_o = q.ovf;

    always_comb begin
        d = q;
        if (push_ok_o) d.wr = (q.wr == LAST) ? '0 : q.wr + 1'b1;
        if (do_pop)    d.rd = (q.rd == LAST) ? '0 : q.rd + 1'b1;
        if (push_ok_o && !do_pop) d.cnt = q.cnt + 1'b1;
        if (!push_ok_o && do_pop) d.cnt = q.cnt - 1'b1;
        if (push_i && full) d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_ok_o) mem_q[q.wr] <= data_i;
    end

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_i && !pop_i) |=> (q.cnt == FULL && $stable(q.wr))); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovf |=> q.ovf); // R9
endmodule

// File: rtl/lsw_host_fsm.sv
module lsw_host_fsm
    import lsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req_i,
    input  logic busy_i,
    input  logic frame_here_i,
    input  logic ping_i,
    input  logic cfm_take_i,
    input  logic ping_take_i,
    output logic awake_o,
    output logic wake_o,
    output logic cfm_pend_o,
    output logic ping_pend_o
);
    typedef struct packed {
        host_st_e st;
        logic     wake;
        logic     cfm;
        logic     ping;
    } hs_t;

    hs_t q, d;

    always_comb begin
        d = q;
        if (cfm_take_i)  d.cfm  = 1'b0;
        if (ping_take_i) d.ping = 1'b0;
        unique case (q.st)
            HS_AWAKE: if (sleep_req_i && !busy_i) begin
                d.st  = HS_SLEEP;
                d.cfm = 1'b1;
            end
            HS_SLEEP: if (frame_here_i) begin
                d.st   = HS_WAIT;
                d.wake = 1'b1;
            end
            HS_WAIT: if (ping_i) begin
                d.st   = HS_AWAKE;
                d.wake = 1'b0;
                d.ping = 1'b1;
            end
            default: d.st = HS_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: HS_AWAKE, wake: 1'b0, cfm: 1'b0, ping: 1'b0};
        else        q <= d;
    end

    assign awake_o     = (q.st == HS_AWAKE);
    assign wake_o      = q.wake;
    assign cfm_pend_o  = q.cfm;
    assign ping_pend_o = q.ping;

    AST_WAKE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wake && !ping_i) |=> q.wake); // R6
    AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.wake) |-> $past(q.st == HS_SLEEP)); // R6
    AST_PING_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.wake) |-> (q.ping && q.st == HS_AWAKE)); // R7
    AST_SLEEP_CFM: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == HS_SLEEP && $past(q.st == HS_AWAKE)) |-> (q.cfm && !$past(busy_i))); // R3
endmodule

// File: rtl/lsw_self_wake.sv
module lsw_self_wake
    import lsw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       doze_i,
    input  logic       rx_activity_i,
    input  logic       rx_ready_i,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_byte_i,
    input  logic       null_take_i,
    output logic       loc_on_o,
    output logic       null_pend_o,
    output logic       rx_pass_o
);
    typedef struct packed {
        loc_st_e st;
        logic    nul;
    } ls_t;

    ls_t q, d;
    logic zero_seen;

    assign zero_seen = rx_ready_i && rx_valid_i && (rx_byte_i == 8'h00);

    always_comb begin
        d = q;
        if (null_take_i) d.nul = 1'b0;
        unique case (q.st)
            LS_ON:     if (doze_i && !q.nul) d.st = LS_DOZE;
            LS_DOZE:   if (rx_activity_i)    d.st = LS_RESYNC;
            LS_RESYNC: if (zero_seen) begin
                d.st  = LS_ON;
                d.nul = 1'b1;
            end
            default:   d.st = LS_ON;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: LS_ON, nul: 1'b0};
        else        q <= d;
    end

    assign loc_on_o    = (q.st == LS_ON);
    assign null_pend_o = q.nul;
    assign rx_pass_o   = rx_valid_i && (q.st == LS_ON);

    AST_NULL_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.nul) |-> $past(rx_valid_i && rx_ready_i && rx_byte_i == 8'h00)); // R11
    AST_NULL_IN_ON_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        q.nul |-> (q.st == LS_ON)); // R11
endmodule

// File: rtl/lsw_tx_arbiter.sv
module lsw_tx_arbiter
    import lsw_pkg::*;
#(
    parameter int         FRAME_W = 16,
    parameter logic [7:0] CFM_CMD = 8'h21
) (
    input  logic               loc_on_i,
    input  logic               null_pend_i,
    input  logic               ping_pend_i,
    input  logic               cfm_pend_i,
    input  logic               host_awake_i,
    input  logic               fifo_empty_i,
    input  logic [FRAME_W-1:0] head_i,
    input  logic               tx_ready_i,
    output logic               tx_valid_o,
    output logic [1:0]         tx_kind_o,
    output logic [FRAME_W-1:0] tx_data_o,
    output logic               null_take_o,
    output logic               ping_take_o,
    output logic               cfm_take_o,
    output logic               pop_o
);
    localparam int PADW = FRAME_W - 8;

    logic data_ok, take;

    assign data_ok = host_awake_i && !fifo_empty_i;
    assign take    = tx_valid_o && tx_ready_i;

    always_comb begin
        tx_valid_o = 1'b0;
        tx_kind_o  = TK_DATA;
        tx_data_o  = '0;
        if (loc_on_i) begin
            if (null_pend_i) begin
                tx_valid_o = 1'b1;
                tx_kind_o  = TK_NULL;
            end else if (ping_pend_i) begin
                tx_valid_o = 1'b1;
                tx_kind_o  = TK_PING;
                tx_data_o  = {{PADW{1'b0}}, PING_CMD};
            end else if (cfm_pend_i) begin
                tx_valid_o = 1'b1;
                tx_kind_o  = TK_CFM;
                tx_data_o  = {{PADW{1'b0}}, CFM_CMD};
            end else if (data_ok) begin
                tx_valid_o = 1'b1;
                tx_kind_o  = TK_DATA;
                tx_data_o  = head_i;
            end
        end
    end

    assign null_take_o = take && (tx_kind_o == TK_NULL);
    assign ping_take_o = take && (tx_kind_o == TK_PING);
    assign cfm_take_o  = take && (tx_kind_o == TK_CFM);
    assign pop_o       = take && (tx_kind_o == TK_DATA);
endmodule

// File: rtl/lsw_ctrl.sv
module lsw_ctrl
    import lsw_pkg::*;
#(
    parameter int         FRAME_W = 16,
    parameter int         DEPTH   = 4,
    parameter logic [7:0] CFM_CMD = 8'h21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid_i,
    input  logic [7:0]         rx_byte_i,
    input  logic               sleep_req_i,
    input  logic               uart_busy_i,
    input  logic               doze_i,
    input  logic               rx_activity_i,
    input  logic               rx_ready_i,
    input  logic               frm_valid_i,
    input  logic [FRAME_W-1:0] frm_data_i,
    output logic               tx_valid_o,
    output logic [1:0]         tx_kind_o,
    output logic [FRAME_W-1:0] tx_data_o,
    input  logic               tx_ready_i,
    output logic               host_wake_o,
    output logic               overflow_o
);
    logic [FRAME_W-1:0] head;
    logic fifo_empty, push_ok, pop;
    logic host_awake, cfm_pend, ping_pend, cfm_take, ping_take;
    logic loc_on, null_pend, null_take, rx_pass, link_busy;

    assign link_busy = uart_busy_i || !fifo_empty || tx_valid_o;

    lsw_frame_fifo #(.FRAME_W(FRAME_W), .DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (frm_valid_i),
        .data_i     (frm_data_i),
        .pop_i      (pop),
        .head_o     (head),
        .empty_o    (fifo_empty),
        .push_ok_o  (push_ok),
        .overflow_o (overflow_o)
    );

    lsw_host_fsm u_host (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_req_i  (sleep_req_i),
        .busy_i       (link_busy),
        .frame_here_i (push_ok || !fifo_empty),
        .ping_i       (rx_pass),
        .cfm_take_i   (cfm_take),
        .ping_take_i  (ping_take),
        .awake_o      (host_awake),
        .wake_o       (host_wake_o),
        .cfm_pend_o   (cfm_pend),
        .ping_pend_o  (ping_pend)
    );

    lsw_self_wake u_self (
        .clk           (clk),
        .rst_n         (rst_n),
        .doze_i        (doze_i),
        .rx_activity_i (rx_activity_i),
        .rx_ready_i    (rx_ready_i),
        .rx_valid_i    (rx_valid_i),
        .rx_byte_i     (rx_byte_i),
        .null_take_i   (null_take),
        .loc_on_o      (loc_on),
        .null_pend_o   (null_pend),
        .rx_pass_o     (rx_pass)
    );

    lsw_tx_arbiter #(.FRAME_W(FRAME_W), .CFM_CMD(CFM_CMD)) u_arb (
        .loc_on_i     (loc_on),
        .null_pend_i  (null_pend),
        .ping_pend_i  (ping_pend),
        .cfm_pend_i   (cfm_pend),
        .host_awake_i (host_awake),
        .fifo_empty_i (fifo_empty),
        .head_i       (head),
        .tx_ready_i   (tx_ready_i),
        .tx_valid_o   (tx_valid_o),
        .tx_kind_o    (tx_kind_o),
        .tx_data_o    (tx_data_o),
        .null_take_o  (null_take),
        .ping_take_o  (ping_take),
        .cfm_take_o   (cfm_take),
        .pop_o        (pop)
    );

    AST_NO_DATA_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && tx_kind_o == TK_DATA) |-> (host_awake && !host_wake_o)); // R5
    AST_SILENT_DOZE: assert property (@(posedge clk) disable iff (!rst_n)
        (doze_i && tx_valid_o && tx_kind_o == TK_DATA) |=> !tx_valid_o); // R10
endmodule

// File: tb/lsw_ctrl_tb.sv
`timescale 1ns/1ps
module lsw_ctrl_tb;
    localparam int FW = 16;
    localparam int DEPTH = 4;
    localparam logic [7:0] CFM = 8'h21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid_i = 0, sleep_req_i = 0, uart_busy_i = 0;
    logic doze_i = 0, rx_activity_i = 0, rx_ready_i = 1;
    logic frm_valid_i = 0, tx_ready_i = 0;
    logic [7:0] rx_byte_i = 0;
    logic [FW-1:0] frm_data_i = 0;
    logic tx_valid_o, host_wake_o, overflow_o;
    logic [1:0] tx_kind_o;
    logic [FW-1:0] tx_data_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lsw_ctrl #(.FRAME_W(FW), .DEPTH(DEPTH), .CFM_CMD(CFM)) u_dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push(input logic [FW-1:0] v);
        frm_data_i = v; frm_valid_i = 1; tick(); frm_valid_i = 0;
    endtask

    task automatic rx(input logic [7:0] b);
        rx_byte_i = b; rx_valid_i = 1; tick(); rx_valid_i = 0;
    endtask

    task automatic take(input string tag, input logic [1:0] k, input logic [FW-1:0] v);
        check({tag, " valid"}, tx_valid_o, 1);
        check({tag, " kind"}, tx_kind_o, k);
        check({tag, " data"}, tx_data_o, v);
        tx_ready_i = 1; tick(); tx_ready_i = 0;
    endtask

    task automatic t_reset();
        check("R1 valid", tx_valid_o, 0);
        check("R1 wake", host_wake_o, 0);
        check("R1 overflow", overflow_o, 0);
    endtask

    task automatic t_awake_pass();
        push(16'hA001); push(16'hA002);
        check("R2 wake", host_wake_o, 0);
        take("R2 first", 2'd0, 16'hA001);
        take("R2 second", 2'd0, 16'hA002);
        check("R2 idle", tx_valid_o, 0);
        rx(8'h77);
        check("R12 awake wake", host_wake_o, 0);
        check("R12 awake tx", tx_valid_o, 0);
    endtask

    task automatic t_sleep_busy();
        uart_busy_i = 1; sleep_req_i = 1; tick(); sleep_req_i = 0; uart_busy_i = 0;
        check("R4 no confirm", tx_valid_o, 0);
        push(16'hB001);
        check("R4 wake low", host_wake_o, 0);
        take("R4 direct", 2'd0, 16'hB001);
    endtask

    task automatic t_sleep_cycle();
        sleep_req_i = 1; tick(); sleep_req_i = 0;
        take("R3 confirm", 2'd1, {8'h00, CFM});
        rx(8'h55);
        check("R12 asleep wake", host_wake_o, 0);
        check("R12 asleep tx", tx_valid_o, 0);
        push(16'hC001);
        check("R6 wake rise", host_wake_o, 1);
        check("R5 no data", tx_valid_o, 0);
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R6 wake held", host_wake_o, 1);
            check("R5 held no data", tx_valid_o, 0);
        end
        push(16'hC002); push(16'hC003); push(16'hC004);
        check("R9 no ovf yet", overflow_o, 0);
        push(16'hC005);
        check("R9 overflow", overflow_o, 1);
        check("R6 wake still", host_wake_o, 1);
        rx(8'h5A);
        check("R7 wake drop", host_wake_o, 0);
        take("R7 ping", 2'd2, 16'h0010);
        take("R8 d1", 2'd0, 16'hC001);
        take("R8 d2", 2'd0, 16'hC002);
        take("R8 d3", 2'd0, 16'hC003);
        take("R8 d4", 2'd0, 16'hC004);
        check("R9 dropped", tx_valid_o, 0);
        tick();
        check("R9 sticky", overflow_o, 1);
    endtask

    task automatic t_doze();
        doze_i = 1; tick(); doze_i = 0;
        push(16'hD001);
        check("R10 silent", tx_valid_o, 0);
        tick();
        check("R10 silent2", tx_valid_o, 0);
        rx_activity_i = 1; tick(); rx_activity_i = 0;
        rx_ready_i = 0;
        rx(8'h00);
        check("R11 not ready", tx_valid_o, 0);
        rx_ready_i = 1;
        rx(8'h33);
        check("R11 nonzero", tx_valid_o, 0);
        rx(8'h00);
        take("R11 null", 2'd3, 16'h0000);
        take("R11 resume", 2'd0, 16'hD001);
        check("R11 wake low", host_wake_o, 0);
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1;
        tick();
        t_reset();
        t_awake_pass();
        t_sleep_busy();
        t_sleep_cycle();
        t_doze();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule